// File: doc/BRIEF.md
# Drift-Compensated System Time Unit

This block keeps a free-running nanosecond time base for a real-time network end node. On every clock it adds a fixed-point increment, 4 integer and 28 fractional nanosecond bits, to a 64-bit nanosecond counter. Software trims the increment to cancel rate drift against a network-wide time. It can also add a signed 64-bit offset to the time for a one-off step correction.

Two services share this time base. A frame-start strobe latches the current time into a holding register, which software drains. Eight event slots each hold an absolute compare time and a priority. Every slot whose time has been reached drives one shared interrupt line. The line is accompanied by the priority and slot of the most urgent pending event, so the interrupt fabric can dispatch in descending priority order. Pending events of equal or lower priority wait until the slots ahead of them are acknowledged.

Top module: `systime_unit`

## Requirements
- R1: After reset the time reads 0, the increment register (address 0) reads 0xA000_0000 (10 ns), `irq`, `irq_prio` and `irq_slot` are 0, the capture status (address 7) reads 0 and no event slot is armed.
- R2: With the reset increment the time advances by exactly 10 on every clock.
- R3: The increment register at address 0 is unsigned, with bits 31:28 in whole nanoseconds and bits 27:0 in units of 2^-28 ns. After each clock the time equals the integer part of the accumulated increments. A write to the register takes effect from the following clock.
- R4: Address 1 stages the low 32 bits of a step. A write to address 2 supplies the high 32 bits, and the 64-bit two's-complement value is added to the time on that same edge, together with the regular advance.
- R5: When `frame_sof` is high during a cycle with no timestamp held, the time present in that cycle is latched. It is read at address 5 (low half) and address 6 (high half). The status at address 7 has bit 0 = timestamp held and bit 1 = overrun.
- R6: A held timestamp is never overwritten, and a strobe that arrives while one is held sets overrun. A read of address 6 releases the holder and clears both status bits. A strobe in the same cycle as that read is captured as a new timestamp.
- R7: Address 8 stages the low half and address 9 the high half of a compare time. A write to address 10 arms the slot given in bits 2:0 with the priority given in bits 10:8. An armed slot is pending whenever time >= compare, including a compare already passed when armed or jumped over by a step.
- R8: `irq` is high exactly when some slot is pending. `irq_prio`/`irq_slot` give the pending slot with the highest priority value, lower slot index first on a tie, and both are 0 when nothing is pending. Address 12 reads the pending mask, with bit i = slot i.
- R9: A write to address 11 with the slot in bits 2:0 disarms that slot, and the next pending slot in priority order is presented from the following cycle. Address 13 reads the armed mask.
- R10: Read data is registered: the value for `rd_addr` appears in the cycle after `rd_en` and holds until the next read. Address 3 reads time bits 31:0 and address 4 reads time bits 63:32. Unlisted addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Time base clock (100 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 32 | Registered read data |
| frame_sof | input | 1 | Frame-start strobe for timestamp capture |
| now_ns | output | 64 | Current time in nanoseconds |
| irq | output | 1 | Shared event interrupt line |
| irq_prio | output | 3 | Priority of the presented pending event |
| irq_slot | output | 3 | Slot of the presented pending event |

## Verification
The time, the captured timestamp, the slot state and the read data are registers, so each changes on the edge that follows the stimulus. `irq`, `irq_prio` and `irq_slot` are decoded from registered state without a further stage, so an arm, acknowledge or step shows on them at that same edge. The bench drives stimulus on the falling edge and updates its behavioural model on the rising edge. It then compares time, interrupt and read data on the next falling edge, which is exactly one edge after each stimulus. Directed checks, made at the falling edge just after the action, cover the tie rule, the past-due arm, the jump over a compare by a step, and the strobe that coincides with a release.

// File: rtl/systime_pkg.sv
package systime_pkg;

    localparam int TIME_W   = 64;
    localparam int FRAC_W   = 28;
    localparam int INC_W    = 32;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 4;
    localparam int PRIO_LSB = 8;
    localparam logic [INC_W-1:0] INC_NOMINAL = 32'hA000_0000;

    typedef logic [TIME_W-1:0] time_t;

    typedef enum logic [ADDR_W-1:0] {
        A_INC      = 4'd0,
        A_STEP_LO  = 4'd1,
        A_STEP_HI  = 4'd2,
        A_TIME_LO  = 4'd3,
        A_TIME_HI  = 4'd4,
        A_CAP_LO   = 4'd5,
        A_CAP_HI   = 4'd6,
        A_CAP_STAT = 4'd7,
        A_CMP_LO   = 4'd8,
        A_CMP_HI   = 4'd9,
        A_EV_ARM   = 4'd10,
        A_EV_ACK   = 4'd11,
        A_EV_PEND  = 4'd12,
        A_EV_ARMED = 4'd13
    } reg_addr_e;

    typedef struct packed {
        logic ovr;
        logic full;
    } cap_stat_t;

    function automatic time_t join_halves(input logic [DATA_W-1:0] hi,
                                          input logic [DATA_W-1:0] lo);
        return {hi, lo};
    endfunction

endpackage

// File: rtl/st_timebase.sv
module st_timebase
    import systime_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [INC_W-1:0] inc_i,
    input  logic             step_en,
    input  time_t            step_i,
    output time_t            now_o
);
    logic [FRAC_W-1:0] frac_q;
    time_t             now_q;
    logic [FRAC_W:0]   frac_sum;
    time_t             advance;

    always_comb begin
        frac_sum = {1'b0, frac_q} + {1'b0, inc_i[FRAC_W-1:0]};
        advance  = time_t'(inc_i[INC_W-1:FRAC_W]) + time_t'(frac_sum[FRAC_W]);
        if (step_en) begin
            advance = advance + step_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            frac_q <= '0;
            now_q  <= '0;
        end else begin
            frac_q <= frac_sum[FRAC_W-1:0];
            now_q  <= now_q + advance;
        end
    end

    assign now_o = now_q;
endmodule

// File: rtl/st_capture.sv
module st_capture
    import systime_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      strobe_i,
    input  logic      release_i,
    input  time_t     now_i,
    output time_t     cap_o,
    output cap_stat_t stat_o
);
    time_t     cap_q;
    cap_stat_t stat_q;
    cap_stat_t stat_n;
    logic      take;

    always_comb begin
        stat_n = stat_q;
        take   = 1'b0;
        if (release_i) begin
            stat_n = '0;
        end
        if (strobe_i) begin
            if (stat_n.full) begin
                stat_n.ovr = 1'b1;
            end else begin
                take        = 1'b1;
                stat_n.full = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q  <= '0;
            stat_q <= '0;
        end else begin
            stat_q <= stat_n;
            if (take) begin
                cap_q <= now_i;
            end
        end
    end

    assign cap_o  = cap_q;
    assign stat_o = stat_q;
endmodule

// File: rtl/st_event_bank.sv
module st_event_bank
    import systime_pkg::*;
#(
    parameter int N_EV   = 8,
    parameter int PRIO_W = 3,
    parameter int SLOT_W = $clog2(N_EV)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     arm_en,
    input  logic                     ack_en,
    input  logic [SLOT_W-1:0]        slot_i,
    input  logic [PRIO_W-1:0]        prio_i,
    input  time_t                    cmp_i,
    input  time_t                    now_i,
    output logic [N_EV-1:0]          pend_o,
    output logic [N_EV-1:0]          armed_o,
    output logic [N_EV*PRIO_W-1:0]   prio_o
);
    for (genvar g = 0; g < N_EV; g++) begin : g_slot
        time_t             cmp_q;
        logic [PRIO_W-1:0] prio_q;
        logic              valid_q;
        logic              hit;

        assign hit = (slot_i == SLOT_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                cmp_q   <= '0;
                prio_q  <= '0;
                valid_q <= 1'b0;
            end else if (arm_en && hit) begin
                cmp_q   <= cmp_i;
                prio_q  <= prio_i;
                valid_q <= 1'b1;
            end else if (ack_en && hit) begin
                valid_q <= 1'b0;
            end
        end

        assign pend_o[g]                   = valid_q && (now_i >= cmp_q);
        assign armed_o[g]                  = valid_q;
        assign prio_o[g*PRIO_W +: PRIO_W]  = prio_q;
    end
endmodule

// File: rtl/st_prio_pick.sv
module st_prio_pick #(
    parameter int N_EV   = 8,
    parameter int PRIO_W = 3,
    parameter int SLOT_W = $clog2(N_EV)
) (
    input  logic [N_EV-1:0]        pend_i,
    input  logic [N_EV*PRIO_W-1:0] prio_i,
    output logic                   hit_o,
    output logic [PRIO_W-1:0]      prio_o,
    output logic [SLOT_W-1:0]      slot_o
);
    always_comb begin
        hit_o  = 1'b0;
        prio_o = '0;
        slot_o = '0;
        for (int i = 0; i < N_EV; i++) begin
            if (pend_i[i] && (!hit_o || (prio_i[i*PRIO_W +: PRIO_W] > prio_o))) begin
                hit_o  = 1'b1;
                prio_o = prio_i[i*PRIO_W +: PRIO_W];
                slot_o = SLOT_W'(i);
            end
        end
    end
endmodule

// File: rtl/systime_unit.sv
module systime_unit
    import systime_pkg::*;
#(
    parameter int N_EV   = 8,
    parameter int PRIO_W = 3,
    localparam int SLOT_W = $clog2(N_EV)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              frame_sof,
    output logic [TIME_W-1:0] now_ns,
    output logic              irq,
    output logic [PRIO_W-1:0] irq_prio,
    output logic [SLOT_W-1:0] irq_slot
);
    logic [INC_W-1:0]    inc_q;
    logic [DATA_W-1:0]   step_lo_q;
    logic [DATA_W-1:0]   cmp_lo_q;
    logic [DATA_W-1:0]   cmp_hi_q;
    logic [DATA_W-1:0]   rd_q;
    logic [DATA_W-1:0]   rd_mux;

    logic                step_wr;
    time_t               step_val;
    logic                arm_wr;
    logic                ack_wr;
    logic                cap_release;
    time_t               now_t;
    time_t               cap_val;
    cap_stat_t           cap_st;
    logic [N_EV-1:0]     pend;
    logic [N_EV-1:0]     armed;
    logic [N_EV*PRIO_W-1:0] prio_flat;

    assign step_wr     = wr_en && (wr_addr == A_STEP_HI);
    assign step_val    = join_halves(wr_data, step_lo_q);
    assign arm_wr      = wr_en && (wr_addr == A_EV_ARM);
    assign ack_wr      = wr_en && (wr_addr == A_EV_ACK);
    assign cap_release = rd_en && (rd_addr == A_CAP_HI);

    always_ff @(posedge clk) begin
        if (rst) begin
            inc_q     <= INC_NOMINAL;
            step_lo_q <= '0;
            cmp_lo_q  <= '0;
            cmp_hi_q  <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_INC:     inc_q     <= wr_data;
                A_STEP_LO: step_lo_q <= wr_data;
                A_CMP_LO:  cmp_lo_q  <= wr_data;
                A_CMP_HI:  cmp_hi_q  <= wr_data;
                default:   ;
            endcase
        end
    end

    st_timebase u_timebase (
        .clk     (clk),
        .rst     (rst),
        .inc_i   (inc_q),
        .step_en (step_wr),
        .step_i  (step_val),
        .now_o   (now_t)
    );

    st_capture u_capture (
        .clk       (clk),
        .rst       (rst),
        .strobe_i  (frame_sof),
        .release_i (cap_release),
        .now_i     (now_t),
        .cap_o     (cap_val),
        .stat_o    (cap_st)
    );

    st_event_bank #(
        .N_EV   (N_EV),
        .PRIO_W (PRIO_W),
        .SLOT_W (SLOT_W)
    ) u_events (
        .clk     (clk),
        .rst     (rst),
        .arm_en  (arm_wr),
        .ack_en  (ack_wr),
        .slot_i  (wr_data[SLOT_W-1:0]),
        .prio_i  (wr_data[PRIO_LSB +: PRIO_W]),
        .cmp_i   (join_halves(cmp_hi_q, cmp_lo_q)),
        .now_i   (now_t),
        .pend_o  (pend),
        .armed_o (armed),
        .prio_o  (prio_flat)
    );

    st_prio_pick #(
        .N_EV   (N_EV),
        .PRIO_W (PRIO_W),
        .SLOT_W (SLOT_W)
    ) u_pick (
        .pend_i (pend),
        .prio_i (prio_flat),
        .hit_o  (irq),
        .prio_o (irq_prio),
        .slot_o (irq_slot)
    );

    always_comb begin
        case (rd_addr)
            A_INC:      rd_mux = inc_q;
            A_TIME_LO:  rd_mux = now_t[DATA_W-1:0];
            A_TIME_HI:  rd_mux = now_t[TIME_W-1:DATA_W];
            A_CAP_LO:   rd_mux = cap_val[DATA_W-1:0];
            A_CAP_HI:   rd_mux = cap_val[TIME_W-1:DATA_W];
            A_CAP_STAT: rd_mux = {{(DATA_W-2){1'b0}}, cap_st};
            A_EV_PEND:  rd_mux = {{(DATA_W-N_EV){1'b0}}, pend};
            A_EV_ARMED: rd_mux = {{(DATA_W-N_EV){1'b0}}, armed};
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else if (rd_en) begin
            rd_q <= rd_mux;
        end
    end

    assign rd_data = rd_q;
    assign now_ns  = now_t;
endmodule

// File: rtl/systime_unit_chk.sv
module systime_unit_chk
    import systime_pkg::*;
#(
    parameter int N_EV   = 8,
    parameter int PRIO_W = 3,
    parameter int SLOT_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input time_t             now_ns,
    input logic [INC_W-1:0]  inc_q,
    input logic              step_wr,
    input time_t             step_val,
    input logic              cap_release,
    input time_t             cap_val,
    input cap_stat_t         cap_st,
    input logic [N_EV-1:0]   pend,
    input logic [N_EV-1:0]   armed,
    input logic              irq,
    input logic [SLOT_W-1:0] irq_slot
);
    // R3: without a step the time moves by the integer increment, plus at most one carry
    p_rate_r3: assert property (@(posedge clk) disable iff (rst)
        !step_wr |=> ((now_ns - $past(now_ns) - time_t'($past(inc_q[INC_W-1:FRAC_W]))) <= time_t'(1)));

    // R4: a step adds its offset on the same edge as the regular advance
    p_step_r4: assert property (@(posedge clk) disable iff (rst)
        step_wr |=> ((now_ns - $past(now_ns) - $past(step_val)
                      - time_t'($past(inc_q[INC_W-1:FRAC_W]))) <= time_t'(1)));

    // R6: a held timestamp stays unchanged until it is released
    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (cap_st.full && !cap_release) |=> (cap_st.full && (cap_val == $past(cap_val))));

    // R6: overrun only exists alongside a held timestamp
    p_ovr_full_r6: assert property (@(posedge clk) disable iff (rst)
        cap_st.ovr |-> cap_st.full);

    // R7: arming makes the slot armed on the next cycle
    p_arm_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == A_EV_ARM) |=> armed[$past(wr_data[SLOT_W-1:0])]);

    // R7: only armed slots can be pending
    p_pend_armed_r7: assert property (@(posedge clk) disable iff (rst)
        (pend & ~armed) == '0);

    // R8: the presented slot is one that is pending
    p_pick_pending_r8: assert property (@(posedge clk) disable iff (rst)
        irq |-> pend[irq_slot]);

    // R9: acknowledging disarms the slot
    p_ack_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == A_EV_ACK) |=> !armed[$past(wr_data[SLOT_W-1:0])]);
endmodule

bind systime_unit systime_unit_chk #(
    .N_EV   (N_EV),
    .PRIO_W (PRIO_W),
    .SLOT_W (SLOT_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .now_ns      (now_ns),
    .inc_q       (inc_q),
    .step_wr     (step_wr),
    .step_val    (step_val),
    .cap_release (cap_release),
    .cap_val     (cap_val),
    .cap_st      (cap_st),
    .pend        (pend),
    .armed       (armed),
    .irq         (irq),
    .irq_slot    (irq_slot)
);

// File: tb/systime_unit_tb.sv
`timescale 1ns/1ps
module systime_unit_tb;
    import systime_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        frame_sof = 1'b0;
    logic [63:0] now_ns;
    logic        irq;
    logic [2:0]  irq_prio;
    logic [2:0]  irq_slot;

    int    checks = 0;
    int    fails  = 0;
    string tag    = "R1";

    always #2 clk = ~clk;

    systime_unit u_dut (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .frame_sof (frame_sof),
        .now_ns    (now_ns),
        .irq       (irq),
        .irq_prio  (irq_prio),
        .irq_slot  (irq_slot)
    );

    // behavioural reference: one wide accumulator in units of 2^-28 ns
    logic [91:0] m_acc;
    logic [31:0] m_inc, m_slo, m_clo, m_chi, m_rdexp;
    logic [63:0] m_cap;
    logic [63:0] m_cmp [8];
    logic [2:0]  m_prio [8];
    bit          m_val [8];
    bit          m_full, m_ovr, m_rdchk;
    string       m_rdtag;

    function automatic logic [63:0] m_now();
        return m_acc[91:28];
    endfunction

    function automatic logic [7:0] m_pend();
        logic [7:0] p;
        for (int i = 0; i < 8; i++) p[i] = m_val[i] && (m_now() >= m_cmp[i]);
        return p;
    endfunction

    function automatic logic [7:0] m_armed();
        logic [7:0] a;
        for (int i = 0; i < 8; i++) a[i] = m_val[i];
        return a;
    endfunction

    task automatic chk(input string t, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s act=%h exp=%h", t, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        logic [63:0] n0;
        if (rst) begin
            m_acc = '0; m_inc = 32'hA000_0000; m_slo = '0; m_clo = '0; m_chi = '0;
            m_cap = '0; m_full = 0; m_ovr = 0; m_rdchk = 0; m_rdexp = '0;
            for (int i = 0; i < 8; i++) begin m_val[i] = 0; m_cmp[i] = '0; m_prio[i] = '0; end
        end else begin
            n0 = m_now();
            m_rdchk = rd_en;
            if (rd_en) begin
                m_rdtag = tag;
                case (rd_addr)
                    4'd0:    m_rdexp = m_inc;
                    4'd3:    m_rdexp = n0[31:0];
                    4'd4:    m_rdexp = n0[63:32];
                    4'd5:    m_rdexp = m_cap[31:0];
                    4'd6:    m_rdexp = m_cap[63:32];
                    4'd7:    m_rdexp = {30'b0, m_ovr, m_full};
                    4'd12:   m_rdexp = {24'b0, m_pend()};
                    4'd13:   m_rdexp = {24'b0, m_armed()};
                    default: m_rdexp = '0;
                endcase
            end
            if (rd_en && rd_addr == 4'd6) begin m_full = 0; m_ovr = 0; end
            if (frame_sof) begin
                if (m_full) m_ovr = 1;
                else begin m_cap = n0; m_full = 1; end
            end
            if (wr_en && wr_addr == 4'd2)
                m_acc = m_acc + {60'b0, m_inc} + ({{28{wr_data[31]}}, wr_data, m_slo} << 28);
            else
                m_acc = m_acc + {60'b0, m_inc};
            if (wr_en) begin
                case (wr_addr)
                    4'd0:  m_inc = wr_data;
                    4'd1:  m_slo = wr_data;
                    4'd8:  m_clo = wr_data;
                    4'd9:  m_chi = wr_data;
                    4'd10: begin
                        m_cmp[wr_data[2:0]]  = {m_chi, m_clo};
                        m_prio[wr_data[2:0]] = wr_data[10:8];
                        m_val[wr_data[2:0]]  = 1;
                    end
                    4'd11: m_val[wr_data[2:0]] = 0;
                    default: ;
                endcase
            end
        end
    end

    // per-cycle comparison against the reference, away from the active edge
    always @(negedge clk) begin
        logic [7:0] p;
        bit         ei;
        logic [2:0] ep, es;
        if (!rst) begin
            p = m_pend(); ei = 0; ep = '0; es = '0;
            for (int i = 0; i < 8; i++) begin
                if (p[i] && (!ei || m_prio[i] > ep)) begin
                    ei = 1; ep = m_prio[i]; es = 3'(i);
                end
            end
            chk(tag, "now_ns", now_ns, m_now());
            chk(tag, "irq", {63'b0, irq}, {63'b0, ei});
            chk(tag, "irq_prio", {61'b0, irq_prio}, {61'b0, ep});
            chk(tag, "irq_slot", {61'b0, irq_slot}, {61'b0, es});
            if (m_rdchk) chk(m_rdtag, "rd_data", {32'b0, rd_data}, {32'b0, m_rdexp});
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic rd(input logic [3:0] a);
        @(negedge clk); rd_en = 1; rd_addr = a;
        @(negedge clk); rd_en = 0;
    endtask

    task automatic step(input logic [63:0] off);
        wr(4'd1, off[31:0]);
        wr(4'd2, off[63:32]);
    endtask

    task automatic arm(input int slot, input int prio, input logic [63:0] when);
        wr(4'd8, when[31:0]);
        wr(4'd9, when[63:32]);
        wr(4'd10, 32'((prio << 8) | slot));
    endtask

    task automatic sof_pulse();
        @(negedge clk); frame_sof = 1;
        @(negedge clk); frame_sof = 0;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired act=running exp=done");
        finish_run();
    end

    initial begin
        logic [63:0] base;
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;

        tag = "R1";
        chk("R1", "now_ns", now_ns, 64'd0);
        chk("R1", "irq", {63'b0, irq}, 64'd0);
        rd(4'd0);  chk("R1", "inc", {32'b0, rd_data}, 64'hA000_0000);
        rd(4'd7);  chk("R1", "cap_stat", {32'b0, rd_data}, 64'd0);
        rd(4'd13); chk("R1", "armed", {32'b0, rd_data}, 64'd0);

        tag = "R2";
        base = now_ns;
        @(negedge clk);
        chk("R2", "now_ns step", now_ns - base, 64'd10);
        repeat (20) @(negedge clk);

        tag = "R3";
        wr(4'd0, 32'h9C00_0000); repeat (30) @(negedge clk);
        wr(4'd0, 32'hA000_0001); repeat (30) @(negedge clk);
        wr(4'd0, 32'hA555_5555); repeat (30) @(negedge clk);
        rd(4'd3); rd(4'd4); rd(4'd0);
        wr(4'd0, 32'hA000_0000);

        tag = "R4";
        step(64'd1000);                repeat (3) @(negedge clk);
        step(64'hFFFF_FFFF_FFFF_FE0C); repeat (3) @(negedge clk);
        step(64'h0000_0001_0000_0000); rd(4'd4);

        tag = "R5";
        sof_pulse();
        rd(4'd7); chk("R5", "cap_stat", {32'b0, rd_data}, 64'd1);
        rd(4'd5); rd(4'd6);

        tag = "R6";
        rd(4'd7); chk("R6", "released", {32'b0, rd_data}, 64'd0);
        sof_pulse(); repeat (2) @(negedge clk); sof_pulse();
        rd(4'd7); chk("R6", "overrun", {32'b0, rd_data}, 64'd3);
        rd(4'd5); rd(4'd6);
        rd(4'd7); chk("R6", "cleared", {32'b0, rd_data}, 64'd0);
        sof_pulse();
        @(negedge clk); rd_en = 1; rd_addr = 4'd6; frame_sof = 1;
        @(negedge clk); rd_en = 0; frame_sof = 0;
        rd(4'd7); chk("R6", "recapture", {32'b0, rd_data}, 64'd1);
        rd(4'd5); rd(4'd6);

        tag = "R7";
        base = m_now();
        arm(2, 3, base + 64'd200);
        arm(5, 6, base + 64'd300);
        arm(1, 3, base + 64'd250);
        repeat (60) @(negedge clk);

        tag = "R8";
        chk("R8", "irq_slot", {61'b0, irq_slot}, 64'd5);
        chk("R8", "irq_prio", {61'b0, irq_prio}, 64'd6);
        rd(4'd12); chk("R8", "pend_mask", {32'b0, rd_data}, 64'h26);

        tag = "R9";
        wr(4'd11, 32'd5);
        chk("R9", "tie lowest slot", {61'b0, irq_slot}, 64'd1);
        chk("R9", "tie prio", {61'b0, irq_prio}, 64'd3);
        wr(4'd11, 32'd1);
        chk("R9", "next slot", {61'b0, irq_slot}, 64'd2);
        wr(4'd11, 32'd2);
        chk("R9", "irq idle", {63'b0, irq}, 64'd0);
        rd(4'd13); chk("R9", "armed", {32'b0, rd_data}, 64'd0);

        tag = "R7";
        arm(0, 7, m_now() - 64'd5);
        chk("R7", "past due irq", {63'b0, irq}, 64'd1);
        chk("R7", "past due slot", {61'b0, irq_slot}, 64'd0);
        wr(4'd11, 32'd0);
        arm(3, 1, m_now() + 64'd100000);
        repeat (5) @(negedge clk);
        chk("R7", "not yet due", {63'b0, irq}, 64'd0);
        step(64'd200000);
        chk("R7", "jumped over", {63'b0, irq}, 64'd1);
        chk("R7", "jumped slot", {61'b0, irq_slot}, 64'd3);
        wr(4'd11, 32'd3);

        tag = "R10";
        rd(4'd0);  chk("R10", "inc", {32'b0, rd_data}, 64'hA000_0000);
        repeat (3) @(negedge clk);
        chk("R10", "held", {32'b0, rd_data}, 64'hA000_0000);
        rd(4'd15); chk("R10", "unmapped", {32'b0, rd_data}, 64'd0);
        rd(4'd3);  rd(4'd4);

        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule